// File: doc/BRIEF.md
# Rectangle Fill Engine with Tiled Pattern and Color Key

This engine paints a rectangular area of a display buffer, one pixel per memory access, in row-major order. It runs in one of three modes. Solid mode writes one constant color everywhere. Pattern mode tiles an 8x8 full-color pattern that is held in off-screen memory, and combines each pattern pixel with the destination pixel through a 4-bit raster operation. Keyed mode tiles the same pattern but leaves a destination pixel unchanged wherever the pattern pixel equals a key color.

A controller sets the configuration inputs and pulses `start`. The engine copies the configuration into its own registers, raises `busy`, and issues reads and writes on a byte-addressed memory port that uses a valid/ready handshake. Each access carries one pixel. The pattern wraps in both directions, and the fill can begin on any of the 64 pattern pixels, which are picked by the low bits of the pattern address. Requests that the engine cannot run are refused with a one-cycle error pulse.

Top module: `fill_blit`

## Requirements
- R1: Solid mode (`mode`=0) writes `fg_color` once to every pixel of the area, in row-major order. Pixel (x, y) is at `dst_start + y*pitch + x*B`, where B is 2 bytes when `bpp16`=1 and 1 byte otherwise.
- R2: When `bpp16`=0, only bits [7:0] of the foreground color, key color, pattern data and destination data are used, and `mem_wdata[15:8]` is 0 on every write.
- R3: The pattern base is `pat_addr` with its low 7 bits cleared (16 bpp) or its low 6 bits cleared (8 bpp). Those low bits divided by B give the start pixel index s, with start row s/8 and start column s%8. Pattern pixel (row, col) is read from `base + (row*8 + col)*B`.
- R4: Within a line the pattern column advances modulo 8, and every new line restarts at the start column. The pattern row advances by one, modulo 8, on each new line, so row 0 follows row 7.
- R5: Pattern mode (`mode`=1) reads the pattern pixel, then the destination pixel, then writes. Result bit i is `rop_code[{p[i], d[i]}]`, so 4'hC copies the pattern, 4'h6 is p XOR d and 4'h3 is NOT p.
- R6: Keyed mode (`mode`=2) issues no write for a pixel whose pattern value equals `key_color`. Every other pixel is written with the pattern value unchanged.
- R7: A start is refused when width or height is 0, when `mode`=3, or when width is below 2 in modes 1 and 2. For a refused start, `err` pulses for one cycle in the cycle after the start, `busy` stays low and no memory request is made. A solid fill with width 1 is accepted.
- R8: An accepted start raises `busy` in the next cycle. `busy` stays high until the final write is accepted. `done` is high for exactly one cycle, and that is the first cycle in which `busy` is low again.
- R9: `start` is ignored while `busy` is high. The configuration inputs are sampled only at an accepted start.
- R10: While `mem_valid` is high and `mem_ready` is low, the address, write enable and write data are held. Read data is taken in the handshake cycle, and no pixel is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| mode | input | 2 | 0 solid, 1 pattern with ROP, 2 keyed pattern, 3 reserved |
| bpp16 | input | 1 | 1: 16-bit pixels, 0: 8-bit pixels |
| dst_start | input | AW (24) | Byte address of the top-left destination pixel |
| pitch | input | AW (24) | Bytes from one destination line to the next |
| width | input | CW (12) | Pixels per line |
| height | input | CW (12) | Lines |
| pat_addr | input | AW (24) | Pattern base address; the low bits give the start pixel |
| fg_color | input | 16 | Solid fill color |
| key_color | input | 16 | Transparency key |
| rop_code | input | 4 | Raster operation for pattern mode |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW (24) | Byte address |
| mem_wdata | output | 16 | Write pixel |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 16 | Read pixel, valid in the accept cycle |

## Verification
The embedded assertions run on every cycle. They check that a stalled request is held steady, that `done` lasts one cycle and only comes while idle, that a refusal never overlaps `busy`, that no request is made while idle, that at 8 bpp the upper byte of every write is zero, that a keyed write never carries the key, and that the position counters stay inside the area. Several properties can only be shown by the bench's scenarios, which compare every write against a reference computed on its own. These are the exact write addresses and data, the pattern wrap in two dimensions from an odd start pixel, the raster-operation results against the prior destination contents, which pixels are skipped in keyed mode, the refusal cases, and the fact that a start issued mid-fill changes nothing.

// File: rtl/fill_blit_pkg.sv
// Package for the fill engine.
// Holds the mode codes, the controller states, the pixel width and the
// raster-operation function. It assumes pixels are at most 16 bits wide.
package fill_blit_pkg;

    localparam int PIXW = 16;

    typedef enum logic [1:0] {
        FILL_SOLID   = 2'd0,
        FILL_PATTERN = 2'd1,
        FILL_KEYED   = 2'd2,
        FILL_RSVD    = 2'd3
    } fill_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PAT_RD = 2'd1,
        ST_DST_RD = 2'd2,
        ST_WRITE  = 2'd3
    } fill_state_e;

    // Bitwise Boolean function: bit i of the result is code[{p[i], d[i]}].
    function automatic logic [PIXW-1:0] rop_apply(input logic [3:0] code,
                                                  input logic [PIXW-1:0] p,
                                                  input logic [PIXW-1:0] d);
        logic [PIXW-1:0] r;
        for (int i = 0; i < PIXW; i++) begin
            r[i] = code[{p[i], d[i]}];
        end
        return r;
    endfunction

endpackage

// File: rtl/fill_blit_walk.sv
// Position walker for the fill engine.
// Tracks the destination pixel (x, y) and the pattern cell (row, col).
// It produces the destination and pattern byte addresses and flags the
// final pixel of the area. It assumes width and height are at least 1
// when load is asserted.
module fill_blit_walk #(
    parameter int AW = 24,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          active,
    input  logic          bpp16,
    input  logic [AW-1:0] dst_start,
    input  logic [AW-1:0] pitch,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic [AW-1:0] pat_addr,
    output logic [AW-1:0] dst_addr,
    output logic [AW-1:0] pat_rd_addr,
    output logic          last_px
);
    localparam int CELLW = 3;

    logic             wide_q;
    logic [AW-1:0]    pitch_q, base_q, line_q;
    logic [CW-1:0]    w_q, h_q, x_q, y_q;
    logic [CELLW-1:0] col0_q, col_q, row_q;
    logic [5:0]       origin;
    logic [AW-1:0]    base_d;

    // Split the pattern address into the aligned base and the start pixel.
    always_comb begin
        if (bpp16) begin
            origin = pat_addr[6:1];
            base_d = {pat_addr[AW-1:7], 7'b0};
        end else begin
            origin = pat_addr[5:0];
            base_d = {pat_addr[AW-1:6], 6'b0};
        end
    end

    // Load the geometry at start, then advance one pixel per step with line and cell wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            pitch_q <= '0;
            base_q  <= '0;
            line_q  <= '0;
            w_q     <= '0;
            h_q     <= '0;
            x_q     <= '0;
            y_q     <= '0;
            col0_q  <= '0;
            col_q   <= '0;
            row_q   <= '0;
        end else if (load) begin
            wide_q  <= bpp16;
            pitch_q <= pitch;
            base_q  <= base_d;
            line_q  <= dst_start;
            w_q     <= width;
            h_q     <= height;
            x_q     <= '0;
            y_q     <= '0;
            col0_q  <= origin[2:0];
            col_q   <= origin[2:0];
            row_q   <= origin[5:3];
        end else if (step && !last_px) begin
            if (x_q == w_q - CW'(1)) begin
                x_q    <= '0;
                y_q    <= y_q + CW'(1);
                col_q  <= col0_q;
                row_q  <= row_q + CELLW'(1);
                line_q <= line_q + pitch_q;
            end else begin
                x_q   <= x_q + CW'(1);
                col_q <= col_q + CELLW'(1);
            end
        end
    end

    // Form the byte addresses from the current position.
    always_comb begin
        dst_addr    = line_q + (wide_q ? (AW'(x_q) << 1) : AW'(x_q));
        pat_rd_addr = base_q + (wide_q ? AW'({row_q, col_q, 1'b0}) : AW'({row_q, col_q}));
        last_px     = (x_q == w_q - CW'(1)) && (y_q == h_q - CW'(1));
    end

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (x_q < w_q) && (y_q < h_q));

endmodule

// File: rtl/fill_blit_pix.sv
// Pixel datapath for the fill engine.
// Produces the write value and the skip flag from the mode, the colors,
// the raster-operation code and the pattern and destination pixels that
// were read. It is purely combinational and masks to 8 bits at 8 bpp.
module fill_blit_pix
    import fill_blit_pkg::*;
(
    input  fill_mode_e       mode,
    input  logic             bpp16,
    input  logic [PIXW-1:0]  fg,
    input  logic [PIXW-1:0]  key,
    input  logic [3:0]       rop,
    input  logic [PIXW-1:0]  pat,
    input  logic [PIXW-1:0]  dst,
    output logic [PIXW-1:0]  wdata,
    output logic             skip
);
    logic [PIXW-1:0] msk, fg_m, key_m, pat_m, dst_m, raw;

    // Select the pixel value per mode and detect a key match.
    always_comb begin
        msk   = bpp16 ? {PIXW{1'b1}} : PIXW'(8'hFF);
        fg_m  = fg & msk;
        key_m = key & msk;
        pat_m = pat & msk;
        dst_m = dst & msk;
        skip  = 1'b0;
        unique case (mode)
            FILL_PATTERN: raw = rop_apply(rop, pat_m, dst_m);
            FILL_KEYED: begin
                raw  = pat_m;
                skip = (pat_m == key_m);
            end
            default: raw = fg_m;
        endcase
        wdata = raw & msk;
    end

endmodule

// File: rtl/fill_blit.sv
// Rectangle fill engine, top level.
// Runs solid, pattern-with-ROP and keyed-pattern fills, one pixel per
// memory access, on a valid/ready port. It assumes the memory returns
// read data combinationally in the cycle the request is accepted.
module fill_blit
    import fill_blit_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      mode,
    input  logic            bpp16,
    input  logic [AW-1:0]   dst_start,
    input  logic [AW-1:0]   pitch,
    input  logic [CW-1:0]   width,
    input  logic [CW-1:0]   height,
    input  logic [AW-1:0]   pat_addr,
    input  logic [15:0]     fg_color,
    input  logic [15:0]     key_color,
    input  logic [3:0]      rop_code,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            mem_valid,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [15:0]     mem_wdata,
    input  logic            mem_ready,
    input  logic [15:0]     mem_rdata
);
    fill_state_e     state_q;
    fill_mode_e      mode_q;
    logic            wide_q, done_q, err_q;
    logic [PIXW-1:0] fg_q, key_q, pat_q, dst_q, pix_w;
    logic [3:0]      rop_q;
    logic            bad_req, accept, step, skip, last_px;
    logic [AW-1:0]   dst_addr, pat_rd_addr;

    // Decide whether a start request can be run.
    always_comb begin
        bad_req = (width == '0) || (height == '0) || (mode == 2'd3) ||
                  ((mode != 2'd0) && (width < CW'(2)));
        accept  = (state_q == ST_IDLE) && start && !bad_req;
        step    = (state_q == ST_WRITE) && (skip || mem_ready);
    end

    fill_blit_walk #(.AW(AW), .CW(CW)) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .step       (step),
        .active     (busy),
        .bpp16      (bpp16),
        .dst_start  (dst_start),
        .pitch      (pitch),
        .width      (width),
        .height     (height),
        .pat_addr   (pat_addr),
        .dst_addr   (dst_addr),
        .pat_rd_addr(pat_rd_addr),
        .last_px    (last_px)
    );

    fill_blit_pix pix_i (
        .mode (mode_q),
        .bpp16(wide_q),
        .fg   (fg_q),
        .key  (key_q),
        .rop  (rop_q),
        .pat  (pat_q),
        .dst  (dst_q),
        .wdata(pix_w),
        .skip (skip)
    );

    // Sequence the reads and writes for each pixel and raise the done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= FILL_SOLID;
            wide_q  <= 1'b0;
            fg_q    <= '0;
            key_q   <= '0;
            rop_q   <= '0;
            pat_q   <= '0;
            dst_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && bad_req) begin
                        err_q <= 1'b1;
                    end else if (accept) begin
                        mode_q  <= fill_mode_e'(mode);
                        wide_q  <= bpp16;
                        fg_q    <= fg_color;
                        key_q   <= key_color;
                        rop_q   <= rop_code;
                        state_q <= (mode == 2'd0) ? ST_WRITE : ST_PAT_RD;
                    end
                end
                ST_PAT_RD: begin
                    if (mem_ready) begin
                        pat_q   <= mem_rdata;
                        state_q <= (mode_q == FILL_PATTERN) ? ST_DST_RD : ST_WRITE;
                    end
                end
                ST_DST_RD: begin
                    if (mem_ready) begin
                        dst_q   <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                default: begin
                    if (skip || mem_ready) begin
                        if (last_px) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= (mode_q == FILL_SOLID) ? ST_WRITE : ST_PAT_RD;
                        end
                    end
                end
            endcase
        end
    end

    // Drive the memory request from the current state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        err       = err_q;
        mem_valid = (state_q == ST_PAT_RD) || (state_q == ST_DST_RD) ||
                    ((state_q == ST_WRITE) && !skip);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_PAT_RD) ? pat_rd_addr : dst_addr;
        mem_wdata = (state_q == ST_WRITE) ? pix_w : '0;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_we) && $stable(mem_wdata));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);
    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !mem_valid);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);
    // R2
    narrow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && !wide_q |-> mem_wdata[15:8] == 8'h00);
    // R6
    key_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && (mode_q == FILL_KEYED) |->
            mem_wdata != (wide_q ? key_q : {8'h00, key_q[7:0]}));

endmodule

// File: tb/fill_blit_tb_top.sv
// Scoreboard bench for the fill engine: the driver task predicts every write into a
// queue, and the monitor pops and compares each accepted write.
module fill_blit_tb_top;
    localparam int AW = 24;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = '0;
    logic bpp16 = 1'b0;
    logic [AW-1:0] dst_start = '0, pitch = '0, pat_addr = '0;
    logic [CW-1:0] width = '0, height = '0;
    logic [15:0] fg_color = '0, key_color = '0;
    logic [3:0] rop_code = '0;
    logic busy, done, err, mem_valid, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic [7:0] mem [4096];
    logic [39:0] exp_q [$];
    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit stall_on = 1'b0;
    bit wide_now = 1'b0;
    string cur_tag = "";

    always #4 clk = ~clk;

    fill_blit #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bpp16(bpp16),
        .dst_start(dst_start), .pitch(pitch), .width(width), .height(height),
        .pat_addr(pat_addr), .fg_color(fg_color), .key_color(key_color),
        .rop_code(rop_code), .busy(busy), .done(done), .err(err),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) cyc <= cyc + 1;
    assign mem_ready = !stall_on || (cyc % 3 != 0);
    assign mem_rdata = wide_now ? {mem[(mem_addr[11:0] + 12'd1)], mem[mem_addr[11:0]]}
                                : {8'h00, mem[mem_addr[11:0]]};

    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata[7:0];
            if (wide_now) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare each accepted write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected write"}, int'({mem_addr, mem_wdata}), 0);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_wdata} == e, {cur_tag, " write addr/data"},
                    int'({mem_addr[15:0], mem_wdata}), int'({e[31:16], e[15:0]}));
            end
        end
    end

    function automatic logic [15:0] rd(input int a, input bit w16);
        return w16 ? {mem[(a + 1) % 4096], mem[a % 4096]} : {8'h00, mem[a % 4096]};
    endfunction

    function automatic logic [15:0] ropf(input logic [3:0] c, input logic [15:0] p, input logic [15:0] d);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = c[{p[i], d[i]}];
        return r;
    endfunction

    task automatic run_job(input logic [1:0] md, input bit w16, input int dst, input int pit,
                           input int w, input int h, input int pa, input logic [15:0] fg,
                           input logic [15:0] key, input logic [3:0] rop, input bit stl,
                           input bit poke, input string tag);
        int msk, base, org, bpb, guard;
        logic [15:0] vm, p, d, f, k, v;
        msk = w16 ? 127 : 63;
        base = pa & ~msk;
        bpb = w16 ? 2 : 1;
        org = (pa & msk) / bpb;
        vm = w16 ? 16'hFFFF : 16'h00FF;
        f = fg & vm;
        k = key & vm;
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int da, pad;
                da = dst + y * pit + x * bpb;
                pad = base + ((((org / 8) + y) % 8) * 8 + ((org % 8) + x) % 8) * bpb;
                p = rd(pad, w16);
                d = rd(da, w16);
                if (md == 2'd0) begin
                    exp_q.push_back({AW'(da), f});
                end else if (md == 2'd1) begin
                    v = ropf(rop, p, d) & vm;
                    exp_q.push_back({AW'(da), v});
                end else if (p != k) begin
                    exp_q.push_back({AW'(da), p});
                end
            end
        end
        cur_tag = tag;
        @(negedge clk);
        wide_now = w16;
        stall_on = stl;
        mode = md; bpp16 = w16; dst_start = AW'(dst); pitch = AW'(pit);
        width = CW'(w); height = CW'(h); pat_addr = AW'(pa);
        fg_color = fg; key_color = key; rop_code = rop; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R8 busy after start"}, int'(busy), 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            mode = 2'd0; fg_color = 16'h1234; width = CW'(1); height = CW'(1);
            dst_start = AW'(0); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, {tag, " R8 done seen"}, int'(done), 1);
        chk(busy == 1'b0, {tag, " R8 busy low with done"}, int'(busy), 0);
        chk(exp_q.size() == 0, {tag, " all writes issued"}, exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        chk(done == 1'b0, {tag, " R8 done one cycle"}, int'(done), 0);
        stall_on = 1'b0;
    endtask

    task automatic refuse(input logic [1:0] md, input int w, input int h, input string tag);
        cur_tag = tag;
        @(negedge clk);
        mode = md; bpp16 = 1'b1; width = CW'(w); height = CW'(h);
        dst_start = AW'(12'h400); pitch = AW'(32); pat_addr = AW'(12'h100); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, {tag, " R7 err pulse"}, int'(err), 1);
        chk(busy == 1'b0 && mem_valid == 1'b0, {tag, " R7 stays idle"}, int'({busy, mem_valid}), 0);
        @(negedge clk);
        chk(err == 1'b0 && busy == 1'b0 && mem_valid == 1'b0, {tag, " R7 err clears"},
            int'({err, busy, mem_valid}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] kk;
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0 && mem_valid == 1'b0,
            "R8 reset state", int'({busy, done, err, mem_valid}), 0);

        run_job(2'd0, 1'b1, 'h400, 32, 5, 3, 'h100, 16'hBEEF, 16'h0, 4'h0, 1'b0, 1'b0, "R1 solid16");
        run_job(2'd0, 1'b0, 'h600, 20, 7, 2, 'h100, 16'hABCD, 16'h0, 4'h0, 1'b1, 1'b0, "R2 R10 solid8");
        run_job(2'd1, 1'b1, 'h800, 40, 10, 10, 'h100, 16'h0, 16'h0, 4'hC, 1'b0, 1'b0, "R3 R4 copy16");
        run_job(2'd1, 1'b0, 'hA00, 16, 9, 4, 'h200 + 46, 16'h0, 16'h0, 4'h6, 1'b1, 1'b0, "R5 R4 R10 xor8");
        kk = rd('h100 + 8, 1'b1);
        run_job(2'd2, 1'b1, 'hB00, 24, 6, 9, 'h100 + 118, 16'h0, kk, 4'h0, 1'b0, 1'b0, "R6 keyed16");
        kk = {8'hFF, mem['h200 + 10]};
        run_job(2'd2, 1'b0, 'hD00, 16, 8, 3, 'h200, 16'h0, kk, 4'h0, 1'b1, 1'b0, "R6 R2 keyed8");
        refuse(2'd1, 1, 4, "R7 pattern width1");
        refuse(2'd2, 1, 4, "R7 keyed width1");
        refuse(2'd3, 4, 4, "R7 reserved mode");
        refuse(2'd0, 0, 4, "R7 zero width");
        refuse(2'd0, 3, 0, "R7 zero height");
        run_job(2'd0, 1'b1, 'h700, 32, 1, 3, 'h100, 16'h5A5A, 16'h0, 4'h0, 1'b0, 1'b0, "R7 R1 solid width1");
        run_job(2'd1, 1'b1, 'hE00, 32, 6, 3, 'h100 + 10, 16'h0, 16'h0, 4'h3, 1'b1, 1'b1, "R9 start while busy");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule